// File: doc/BRIEF.md
# Clock-Fail Interrupt Watchdog

This block watches a clock-failure indication from a missing-clock detector. The indication comes from another clock domain and passes through a synchronizer first. A failure then sets a sticky failure flag, a sticky missing-clock status bit and a global interrupt flag. The first cycle of the global flag produces a one-cycle non-maskable interrupt pulse. Software answers the interrupt by writing clear bits in a command register. A force bit in the same register raises the failure flag for testing.

When software does not answer, a reset request follows. A configuration bit selects between two outcomes. With the bit set, the request is made at once. With the bit clear, a 16-bit counter runs on the system clock while the global flag is pending, and the request is made when the count reaches a programmable period. The request is held high for a fixed number of cycles.

Write port map: `wr_sel` 0 is the command register, 1 is the configuration register (bit 0 selects instant reset) and 2 is the period register (all 16 bits). The command bits are: bit 0 clears the failure flag, bit 1 clears the global flag, bit 2 forces the failure flag. A write takes effect on the clock edge that samples it.

Top module: `clkfail_nmi_wdog`

## Requirements
- R1: A high `clk_fail_in` sets `fail_flag`. The flag stays set after the input drops. Only a command write with bit 0 set clears it.
- R2: A real clock-fail event sets `miss_sts`. A force write does not set it. Only `rst` clears it.
- R3: When configuration bit 0 is 1, `rst_req` rises one cycle after `global_flag` rises.
- R4: When configuration bit 0 is 0, `wd_count` is 0 in the first cycle of `global_flag` and rises by one each cycle. When the count reaches the period value P, `rst_req` rises in the next cycle, which is P+1 cycles after the global flag rose. The count then stops at P.
- R5: `global_flag` sets in the same cycle that any failure flag setting occurs. A command write with bit 1 set clears it. `nmi_pulse` is high for exactly one cycle, and that cycle is the first cycle of `global_flag`.
- R6: A command write with bit 2 set sets `fail_flag`. When bit 2 and bit 0 are written together, the flag stays set.
- R7: While `global_flag` is clear and `fail_flag` is set, `wd_count` holds its value. Once both flags are clear, `wd_count` returns to 0 one cycle later.
- R8: Each trip holds `rst_req` high for exactly 8 cycles. There is no further trip until both flags have been cleared.
- R9: `rst` clears all flags, the status bit, the counter and `rst_req`.
- R10: The fail input passes through a two-stage synchronizer. A one-cycle input pulse shows on `fail_flag` after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| clk_fail_in | input | 1 | Asynchronous clock-failure indication |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 configuration, 2 period |
| wr_data | input | 16 | Write data |
| nmi_pulse | output | 1 | One-cycle interrupt pulse |
| fail_flag | output | 1 | Sticky clock-failure flag |
| global_flag | output | 1 | Global interrupt flag |
| miss_sts | output | 1 | Missing-clock status |
| wd_count | output | 16 | Current watchdog count |
| rst_req | output | 1 | Reset request |

## Verification
Some states are hard to reach from the ports. One is a failure flag that is still set while the global flag has been cleared, with the counter frozen partway through a timeout. Another is a trip that has already fired while its flags are still pending. The stimulus reaches both with force writes. It clears the global flag alone at a known count, checks that the count holds, and only then clears the failure flag. After a trip, it keeps both flags pending for many cycles to show that no second request is made. A table of period and mode pairs sets the exact trip latency for each case. The table includes a period of zero.

// File: rtl/nmi_wdog_pkg.sv
package nmi_wdog_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD = 2'd0,
        SEL_CFG = 2'd1,
        SEL_PRD = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CMD_CLR_FAIL_BIT = 0;
    localparam int CMD_CLR_GLOB_BIT = 1;
    localparam int CMD_FORCE_BIT    = 2;
    localparam int CFG_INSTANT_BIT  = 0;

    typedef struct packed {
        logic force_fail;
        logic clr_glob;
        logic clr_fail;
    } nmi_cmd_t;

    function automatic nmi_cmd_t decode_cmd(input logic wen, input reg_sel_e sel,
                                            input logic [CMD_FORCE_BIT:0] bits);
        nmi_cmd_t c;
        logic hit;
        hit          = wen && (sel == SEL_CMD);
        c.clr_fail   = hit && bits[CMD_CLR_FAIL_BIT];
        c.clr_glob   = hit && bits[CMD_CLR_GLOB_BIT];
        c.force_fail = hit && bits[CMD_FORCE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nmi_flag_unit.sv
module nmi_flag_unit
    import nmi_wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fail_evt,
    input  nmi_cmd_t cmd,
    output logic     fail_flag,
    output logic     global_flag,
    output logic     miss_sts,
    output logic     nmi_pulse
);
    logic fail_q, glob_q, miss_q, pulse_q;
    logic set_fail, fail_d, glob_d;

    always_comb begin
        set_fail = fail_evt | cmd.force_fail;
        fail_d   = set_fail | (fail_q & ~cmd.clr_fail);
        glob_d   = set_fail | (glob_q & ~cmd.clr_glob);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q  <= 1'b0;
            glob_q  <= 1'b0;
            miss_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            fail_q  <= fail_d;
            glob_q  <= glob_d;
            miss_q  <= miss_q | fail_evt;
            pulse_q <= glob_d & ~glob_q;
        end
    end

    assign fail_flag   = fail_q;
    assign global_flag = glob_q;
    assign miss_sts    = miss_q;
    assign nmi_pulse   = pulse_q;
endmodule

// File: rtl/nmi_timeout_unit.sv
module nmi_timeout_unit #(
    parameter int CNT_W       = 16,
    parameter int HOLD_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_flag,
    input  logic             global_flag,
    input  logic             instant,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             rst_req
);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES);

    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              fired_q;
    logic              idle, trip, run;

    always_comb begin
        idle = !fail_flag && !global_flag;
        trip = global_flag && !fired_q && (instant || (cnt_q >= period));
        run  = global_flag && !fired_q && (cnt_q < period);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (idle)      cnt_q <= '0;
            else if (run)  cnt_q <= cnt_q + 1'b1;

            if (idle)      fired_q <= 1'b0;
            else if (trip) fired_q <= 1'b1;

            if (trip)                 hold_q <= HOLD_LOAD;
            else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign rst_req = (hold_q != '0);
endmodule

// File: rtl/clkfail_nmi_wdog.sv
module clkfail_nmi_wdog
    import nmi_wdog_pkg::*;
#(
    parameter int                    COUNT_W     = 16,
    parameter int                    SYNC_STAGES = 2,
    parameter int                    HOLD_CYCLES = 8,
    parameter logic [COUNT_W-1:0]    PERIOD_RST  = 16'h00FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_fail_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [COUNT_W-1:0] wr_data,
    output logic               nmi_pulse,
    output logic               fail_flag,
    output logic               global_flag,
    output logic               miss_sts,
    output logic [COUNT_W-1:0] wd_count,
    output logic               rst_req
);
    logic               fail_evt;
    nmi_cmd_t           cmd;
    reg_sel_e           sel;
    logic               instant_q;
    logic [COUNT_W-1:0] period_q;

    assign sel = reg_sel_e'(wr_sel);
    assign cmd = decode_cmd(wr_en, sel, wr_data[CMD_FORCE_BIT:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            instant_q <= 1'b0;
            period_q  <= PERIOD_RST;
        end else if (wr_en) begin
            if (sel == SEL_CFG) instant_q <= wr_data[CFG_INSTANT_BIT];
            if (sel == SEL_PRD) period_q  <= wr_data;
        end
    end

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (clk_fail_in),
        .q   (fail_evt)
    );

    nmi_flag_unit u_flags (
        .clk         (clk),
        .rst         (rst),
        .fail_evt    (fail_evt),
        .cmd         (cmd),
        .fail_flag   (fail_flag),
        .global_flag (global_flag),
        .miss_sts    (miss_sts),
        .nmi_pulse   (nmi_pulse)
    );

    nmi_timeout_unit #(.CNT_W(COUNT_W), .HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .fail_flag   (fail_flag),
        .global_flag (global_flag),
        .instant     (instant_q),
        .period      (period_q),
        .count       (wd_count),
        .rst_req     (rst_req)
    );
endmodule

// File: rtl/nmi_wdog_chk.sv
module nmi_wdog_chk #(
    parameter int COUNT_W     = 16,
    parameter int HOLD_CYCLES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               clr_fail_wr,
    input logic               nmi_pulse,
    input logic               fail_flag,
    input logic               global_flag,
    input logic               miss_sts,
    input logic [COUNT_W-1:0] wd_count,
    input logic               rst_req
);
    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (rst_req) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !clr_fail_wr) |=> fail_flag); // R1

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        miss_sts |=> miss_sts); // R2

    AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(global_flag)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(wd_count) |-> (wd_count == '0 || wd_count == $past(wd_count) + 1'b1)); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |=> !nmi_pulse); // R5

    AST_PULSE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |-> (global_flag && !$past(global_flag))); // R5

    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!fail_flag && !global_flag) |=> (wd_count == '0)); // R7

    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> (run_len == 8'(HOLD_CYCLES))); // R8
endmodule

bind clkfail_nmi_wdog nmi_wdog_chk #(.COUNT_W(COUNT_W), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_fail_wr (wr_en && (wr_sel == 2'd0) && wr_data[0]),
    .nmi_pulse   (nmi_pulse),
    .fail_flag   (fail_flag),
    .global_flag (global_flag),
    .miss_sts    (miss_sts),
    .wd_count    (wd_count),
    .rst_req     (rst_req)
);

// File: tb/clkfail_nmi_wdog_bench.sv
module clkfail_nmi_wdog_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_fail_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        nmi_pulse, fail_flag, global_flag, miss_sts, rst_req;
    logic [15:0] wd_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    clkfail_nmi_wdog u_clkfail_nmi_wdog (
        .clk(clk), .rst(rst), .clk_fail_in(clk_fail_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .nmi_pulse(nmi_pulse), .fail_flag(fail_flag), .global_flag(global_flag),
        .miss_sts(miss_sts), .wd_count(wd_count), .rst_req(rst_req)
    );

    // {instant, period}
    localparam logic [16:0] VEC [0:4] = '{
        {1'b0, 16'd0}, {1'b0, 16'd3}, {1'b0, 16'd10}, {1'b0, 16'd37}, {1'b1, 16'd20}
    };

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run hung)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, wid;
        step();
        do_reset();
        // R9 reset state
        check("R9 fail_flag after reset", fail_flag, 0);
        check("R9 global_flag after reset", global_flag, 0);
        check("R9 miss_sts after reset", miss_sts, 0);
        check("R9 wd_count after reset", wd_count, 0);
        check("R9 rst_req after reset", rst_req, 0);

        // R10 / R1 / R2: real fail pulse through synchronizer
        clk_fail_in = 1'b1;
        step();
        clk_fail_in = 1'b0;
        step();
        check("R10 flag not yet set after two edges", fail_flag, 0);
        step();
        check("R10 flag set after three edges", fail_flag, 1);
        check("R2 miss_sts set by real fail", miss_sts, 1);
        check("R5 global set with fail flag", global_flag, 1);
        check("R5 nmi_pulse in first global cycle", nmi_pulse, 1);
        step();
        check("R5 nmi_pulse lasts one cycle", nmi_pulse, 0);
        step(3);
        check("R1 flag sticky after input drops", fail_flag, 1);
        wr(2'd0, 16'h0003);
        check("R1 flag cleared by command bit 0", fail_flag, 0);
        check("R5 global cleared by command bit 1", global_flag, 0);
        check("R2 miss_sts survives flag clear", miss_sts, 1);
        step();
        check("R7 count zero once both flags clear", wd_count, 0);

        // R9: reset clears status
        do_reset();
        check("R9 miss_sts cleared by reset", miss_sts, 0);

        // R6 / R2: force and force-over-clear
        wr(2'd2, 16'd100);
        wr(2'd0, 16'h0005);
        check("R6 force over clear keeps flag set", fail_flag, 1);
        check("R2 force does not set miss_sts", miss_sts, 0);
        check("R4 count zero in first global cycle", wd_count, 0);
        step(4);
        check("R4 count increments per cycle", wd_count, 4);
        wr(2'd0, 16'h0002);
        check("R5 global cleared alone", global_flag, 0);
        check("R7 fail flag remains set", fail_flag, 1);
        check("R7 count at global clear", wd_count, 5);
        step(3);
        check("R7 count holds with global clear", wd_count, 5);
        wr(2'd0, 16'h0001);
        check("R1 fail flag cleared", fail_flag, 0);
        step();
        check("R7 count returns to zero", wd_count, 0);
        step(3);

        // Table walk: R3 / R4 / R8
        for (int i = 0; i < 5; i++) begin
            logic inst;
            logic [15:0] per;
            inst = VEC[i][16];
            per  = VEC[i][15:0];
            wr(2'd1, {15'd0, inst});
            wr(2'd2, per);
            wr(2'd0, 16'h0004);
            lat = 0;
            do begin
                step();
                lat++;
            end while (!rst_req && lat < 300);
            if (inst) check($sformatf("R3 instant trip latency vec %0d", i), lat, 1);
            else      check($sformatf("R4 timeout trip latency vec %0d", i), lat, int'(per) + 1);
            wid = 0;
            while (rst_req && wid < 50) begin
                step();
                wid++;
            end
            check($sformatf("R8 request width vec %0d", i), wid, 8);
            if (!inst) check($sformatf("R4 count stopped at period vec %0d", i), wd_count, int'(per));
            if (i == 2) begin
                step(20);
                check("R8 no retrip while flags pending", rst_req, 0);
            end
            wr(2'd0, 16'h0003);
            step(2);
            check($sformatf("R7 count cleared vec %0d", i), wd_count, 0);
        end

        // R9: reset during pending timeout
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0004);
        step(3);
        do_reset();
        check("R9 flags and count cleared mid-run", int'({fail_flag, global_flag}) + int'(wd_count), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule